// File: doc/BRIEF.md
# Block Write-Protection Unit

This unit sits beside the command controller of a serial memory with a supervisory function. It decides whether a pending write may go ahead. The write is either a write into the memory array or a write to the status register. To decide, the unit combines four things: the two-bit block-protect code, the protect-enable bit, the active-low hardware protect pin, and the write-enable latch. The command controller raises a one-cycle request at the point where the internal write cycle would start. It states whether the target is the status register, and for an array write it gives the starting address. One cycle later the unit answers with a single grant pulse or a single deny pulse.

The protected region always comes from the top of the array. It is a quarter, a half or the whole of it, and its bounds are derived from the address-width parameter, so every array size from 256 bytes to 4 KiB is covered. For a page write, only the starting address is checked: if that address is protected, the whole write is refused.

Hardware protection is active only while the pin is low and protect-enable is set. While the controller is shifting in a status write inside an open chip-select window, the unit watches the pin. If hardware protection becomes active, the unit pulses an abort and marks that status write as cancelled. The mark is cleared when chip select next falls. Once chip select has risen and the internal write has been granted, later changes on the pin have no effect.

Top module: `blockWriteGuard`

## Requirements
- R1: For an array write with the write-enable latch set, the block-protect code selects the refused addresses, counted from the top of a 2^ADDR_W-byte array: code 0 refuses none, code 1 refuses the top quarter, code 2 refuses the top half, and code 3 refuses every address. Any other address is granted.
- R2: When the write-enable latch is 0, every request is denied, whatever the pin, protect-enable and block-protect code are.
- R3: When the pin is low and protect-enable is 1, a status write request is denied.
- R4: When protect-enable is 0 or the pin is high, the pin has no effect. A status write with the latch set is granted, and no abort is produced.
- R5: When hardware protection is active, an array write outside the protected region is still granted if the latch is set. An array write inside the region is denied.
- R6: Chip select (active low) may be low while the status-write arm input is high. If the pin is low and protect-enable is 1 in such a cycle, abortO pulses for exactly one cycle, in the next cycle, once per window. Any status request made before chip select next falls is then denied.
- R7: While chip select is high, or while the status-write arm input is low, the pin never produces an abort. A change on the pin after a grant has no effect on any output.
- R8: Each request gives exactly one of grantO and denyO, as a one-cycle pulse in the cycle after the request. Neither output is ever high without a request in the cycle before.
- R9: During and right after reset (active low), grantO, denyO and abortO are 0 and no cancel mark is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| wpN | input | 1 | Hardware protect pin, active low |
| statusArm | input | 1 | High while a status write is being shifted in |
| bpCode | input | 2 | Block-protect code |
| wpenBit | input | 1 | Protect-enable bit |
| welBit | input | 1 | Write-enable latch |
| reqValid | input | 1 | One-cycle write request |
| reqIsStatus | input | 1 | Request targets the status register |
| reqAddr | input | ADDR_W | Starting address of an array write |
| grantO | output | 1 | Write allowed (pulse) |
| denyO | output | 1 | Write refused (pulse) |
| abortO | output | 1 | Status write cancelled by the pin (pulse) |

## Verification
Every result comes from exactly one register stage. A request sampled at a rising edge shows up as a grant or deny pulse right after that edge. An abort condition sampled at an edge shows up as an abort pulse after the same edge. The cancel mark it sets takes part in decisions from the next edge onward. The bench drives inputs just after each rising edge. Its reference model updates at the same edge the design samples, and it compares all three outputs at the following falling edge, so every expected value lands in exactly the cycle where it is due.

// File: rtl/wpuPkg.sv
package wpuPkg;
  // strobes from the window controller to the decision datapath
  typedef struct packed {
    logic cancelled;  // status write in this window already cancelled
    logic abortNow;   // cancel condition first seen this cycle
  } wpuStrobes_t;
endpackage

// File: rtl/wpuCtrl.sv
module wpuCtrl
  import wpuPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        statusArm,
  input  logic        hwProt,
  output wpuStrobes_t strb
);
  logic csPrev;
  logic cancelQ;
  logic csFall;
  logic setCond;

  assign csFall  = csPrev & ~csN;
  assign setCond = statusArm & ~csN & hwProt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev  <= 1'b1;
      cancelQ <= 1'b0;
    end else begin
      csPrev <= csN;
      if (setCond)     cancelQ <= 1'b1;
      else if (csFall) cancelQ <= 1'b0;
    end
  end

  always_comb begin
    strb.cancelled = cancelQ;
    strb.abortNow  = setCond & ~cancelQ;
  end
endmodule

// File: rtl/wpuData.sv
module wpuData
  import wpuPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        bpCode,
  input  logic              wpenBit,
  input  logic              wpN,
  input  logic              welBit,
  input  logic              reqValid,
  input  logic              reqIsStatus,
  input  logic [ADDR_W-1:0] reqAddr,
  input  wpuStrobes_t       strb,
  output logic              hwProt,
  output logic              grantO,
  output logic              denyO,
  output logic              abortO
);
  localparam int TOP = ADDR_W - 1;

  logic [1:0] topBits;
  logic       inProt;
  logic       statusOk;
  logic       memOk;
  logic       allow;

  assign hwProt  = wpenBit & ~wpN;
  assign topBits = reqAddr[TOP -: 2];

  always_comb begin
    unique case (bpCode)
      2'd0:    inProt = 1'b0;
      2'd1:    inProt = &topBits;
      2'd2:    inProt = topBits[1];
      default: inProt = 1'b1;
    endcase
  end

  assign statusOk = welBit & ~hwProt & ~strb.cancelled & ~strb.abortNow;
  assign memOk    = welBit & ~inProt;
  assign allow    = reqIsStatus ? statusOk : memOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantO <= 1'b0;
      denyO  <= 1'b0;
      abortO <= 1'b0;
    end else begin
      grantO <= reqValid & allow;
      denyO  <= reqValid & ~allow;
      abortO <= strb.abortNow;
    end
  end
endmodule

// File: rtl/blockWriteGuard.sv
module blockWriteGuard
  import wpuPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wpN,
  input  logic              statusArm,
  input  logic [1:0]        bpCode,
  input  logic              wpenBit,
  input  logic              welBit,
  input  logic              reqValid,
  input  logic              reqIsStatus,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              grantO,
  output logic              denyO,
  output logic              abortO
);
  wpuStrobes_t strb;
  logic        hwProt;

  wpuCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .statusArm(statusArm),
    .hwProt(hwProt), .strb(strb)
  );

  wpuData #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .bpCode(bpCode), .wpenBit(wpenBit), .wpN(wpN),
    .welBit(welBit), .reqValid(reqValid), .reqIsStatus(reqIsStatus),
    .reqAddr(reqAddr), .strb(strb), .hwProt(hwProt),
    .grantO(grantO), .denyO(denyO), .abortO(abortO)
  );
endmodule

// File: rtl/wpuChecker.sv
module wpuChecker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              wpN,
  input logic              statusArm,
  input logic [1:0]        bpCode,
  input logic              wpenBit,
  input logic              welBit,
  input logic              reqValid,
  input logic              reqIsStatus,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              grantO,
  input logic              denyO,
  input logic              abortO
);
  p_half_top_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqIsStatus && bpCode == 2'd2 && reqAddr[ADDR_W-1]) |=> denyO);

  p_no_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !welBit) |=> denyO);

  p_hw_status_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIsStatus && !wpN && wpenBit) |=> denyO);

  p_full_array_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqIsStatus && bpCode == 2'd3) |=> denyO);

  p_abort_window_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(abortO) |-> $past(!csN && statusArm && !wpN && wpenBit));

  p_abort_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    abortO |=> !abortO);

  p_no_pin_effect_r7: assert property (@(posedge clk) disable iff (!rstN)
    (csN || !statusArm) |=> !abortO);

  p_one_answer_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({grantO, denyO}));

  p_answer_due_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (grantO || denyO));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!grantO && !denyO));
endmodule

bind blockWriteGuard wpuChecker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/blockWriteGuard_tb.sv
`timescale 1ns/1ps
module blockWriteGuard_tb;
  localparam int AW   = 9;
  localparam int SIZE = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, wpN = 1'b1, statusArm = 1'b0;
  logic [1:0] bpCode = 2'd0;
  logic wpenBit = 1'b0, welBit = 1'b0;
  logic reqValid = 1'b0, reqIsStatus = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic grantO, denyO, abortO;

  int total = 0;
  int bad = 0;
  string curReq = "R9";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  blockWriteGuard #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .wpN(wpN), .statusArm(statusArm),
    .bpCode(bpCode), .wpenBit(wpenBit), .welBit(welBit), .reqValid(reqValid),
    .reqIsStatus(reqIsStatus), .reqAddr(reqAddr),
    .grantO(grantO), .denyO(denyO), .abortO(abortO)
  );

  // behavioural reference model
  bit mCancel = 0, mCsPrev = 1;
  bit eG = 0, eD = 0, eA = 0;

  function automatic bit isProt(input int code, input int addr);
    case (code)
      0: return 0;
      1: return addr >= (SIZE * 3) / 4;
      2: return addr >= SIZE / 2;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCancel = 0; mCsPrev = 1; eG = 0; eD = 0; eA = 0;
    end else begin
      bit hw, setNow, fall, ok;
      hw     = !wpN && wpenBit;
      setNow = statusArm && !csN && hw && !mCancel;
      fall   = mCsPrev && !csN;
      if (reqIsStatus) ok = welBit && !hw && !mCancel && !setNow;
      else             ok = welBit && !isProt(bpCode, reqAddr);
      eG = reqValid && ok;
      eD = reqValid && !ok;
      eA = setNow;
      if (setNow)    mCancel = 1;
      else if (fall) mCancel = 0;
      mCsPrev = csN;
    end
  end

  always @(negedge clk) begin
    total++;
    if ({grantO, denyO, abortO} !== {eG, eD, eA}) begin
      bad++;
      $display("FAIL %s: grant/deny/abort actual=%b%b%b expected=%b%b%b",
               curReq, grantO, denyO, abortO, eG, eD, eA);
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic request(input bit isStat, input int addr);
    reqIsStatus = isStat; reqAddr = addr[AW-1:0]; reqValid = 1'b1;
    step();
    reqValid = 1'b0;
    step();
  endtask

  initial begin
    curReq = "R9";
    step(3);
    rstN = 1'b1;
    step(2);

    // R1: ranges per code, latch set, no hardware protection
    curReq = "R1";
    welBit = 1'b1; wpenBit = 1'b0; wpN = 1'b1;
    for (int c = 0; c < 4; c++) begin
      bpCode = c[1:0];
      request(0, 0);
      request(0, SIZE / 2 - 1);
      request(0, SIZE / 2);
      request(0, (SIZE * 3) / 4 - 1);
      request(0, (SIZE * 3) / 4);
      request(0, SIZE - 1);
    end

    // R2: no latch, nothing allowed
    curReq = "R2";
    welBit = 1'b0; bpCode = 2'd0;
    request(0, 0);
    request(1, 0);
    wpenBit = 1'b1; wpN = 1'b0;
    request(1, 0);

    // R3: hardware protection refuses status writes
    curReq = "R3";
    welBit = 1'b1;
    request(1, 0);

    // R4: pin ignored when protect-enable off or pin high
    curReq = "R4";
    wpenBit = 1'b0; wpN = 1'b0;
    csN = 1'b0; statusArm = 1'b1; step(2);
    csN = 1'b1; statusArm = 1'b0;
    request(1, 0);
    wpenBit = 1'b1; wpN = 1'b1;
    request(1, 0);

    // R5: array writes under hardware protection
    curReq = "R5";
    wpN = 1'b0; bpCode = 2'd1;
    request(0, 3);
    request(0, SIZE - 2);
    wpN = 1'b1;

    // R6: pin drop during an armed window cancels the status write
    curReq = "R6";
    bpCode = 2'd0;
    csN = 1'b0; step();
    statusArm = 1'b1; step(3);
    wpN = 1'b0; step(4);
    wpN = 1'b1; step();
    wpN = 1'b0; step();
    wpN = 1'b1; csN = 1'b1; statusArm = 1'b0; step();
    request(1, 0);
    csN = 1'b0; step(2);
    csN = 1'b1; step();
    request(1, 0);

    // R7: pin changes after a grant or outside an armed window do nothing
    curReq = "R7";
    wpN = 1'b0; step(3);
    csN = 1'b0; step(3);
    wpN = 1'b1; step();
    wpN = 1'b0; step(2);
    csN = 1'b1; wpN = 1'b1; step(2);

    // R8: answers only after requests, back-to-back requests
    curReq = "R8";
    reqIsStatus = 1'b0; reqAddr = '0; reqValid = 1'b1; step(3);
    reqValid = 1'b0; step(3);

    // R9: reset mid-run clears the cancel mark
    curReq = "R9";
    wpenBit = 1'b1; wpN = 1'b0; csN = 1'b0; statusArm = 1'b1; step(2);
    statusArm = 1'b0; csN = 1'b1; wpN = 1'b1;
    rstN = 1'b0; step(2);
    rstN = 1'b1; step();
    request(1, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule